// File: doc/BRIEF.md
# Clock gear and doubler controller

This block decides how fast a small microcontroller's core and its external bus run. Every rate is a single-cycle enable strobe on one fast master clock. No derived clock is generated. Two raw rate strobes arrive from outside. One comes from the oscillator, and the block halves it to make the slow source. The other is the PLL output strobe. A control word written over a simple write port picks the source, a gear ratio of 1/1, 1/2, 1/4 or 1/8, an optional doubler, and the PLL multiplication code that is driven out to the PLL.

With the doubler off, the core enable and the bus enable pulse together at the geared rate. With the doubler on, the gear is overridden to 1/1. The core then runs at the full source rate and the bus runs at half of it. Some changes are only safe while the slow source is in use. These are turning the doubler off and changing the PLL code. Writes that break these rules, or that would select the one forbidden full-speed combination, are dropped and flag a sticky error.

Top module: `clkgear_ctrl`

## Requirements
- R1: The control word bits are: bit 0 source (0 = halved oscillator, 1 = PLL), bits 2:1 gear code g (ratio 1/2^g), bit 3 doubler enable, bits 5:4 PLL code, bit 6 error clear. A write is applied on the clock edge where `wr_en` is high.
- R2: With the doubler off, `cpu_en` pulses once per 2^g source strobes, and `bus_en` pulses in the same cycle as every `cpu_en`. The halved-oscillator source strobes on every second `osc_tick`. The PLL source strobe is `pll_tick`.
- R3: With the doubler on, `eff_gear` reads 0 whatever the gear field holds. `cpu_en` then pulses once per source strobe, and `bus_en` pulses on every second `cpu_en` pulse.
- R4: A write that clears the doubler bit while the doubler is on and the PLL source is selected is rejected.
- R5: A write that changes the PLL code while the PLL source is selected is rejected.
- R6: A write that would give PLL source, doubler off, gear code 0 and PLL code 3 is rejected. The block never holds that combination.
- R7: A rejected write changes no setting and sets `cfg_err`. The flag stays set until it is cleared.
- R8: An accepted write with bit 6 set clears `cfg_err`. A rejected write leaves it set even if bit 6 is set.
- R9: A change of effective gear or doubler takes effect only at the next `cpu_en` boundary, so the period in progress completes at its old length.
- R10: After reset the halved-oscillator source, gear code 0, doubler off and PLL code 0 are selected. `cfg_err` is 0 and neither enable is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_tick | input | 1 | Oscillator-rate strobe |
| pll_tick | input | 1 | PLL-rate strobe |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 7 | Control word (layout in R1) |
| cpu_en | output | 1 | Internal core clock enable |
| bus_en | output | 1 | External bus clock enable |
| src_pll | output | 1 | Selected source, 1 = PLL |
| gear_sel | output | 2 | Stored gear field |
| dbl_on | output | 1 | Stored doubler bit |
| pll_mul | output | 2 | Stored PLL code, driven to the PLL |
| eff_gear | output | 2 | Gear code in use by the divider |
| cfg_err | output | 1 | Sticky rejected-write flag |

## Verification
The assertions take it for granted that the two rate strobes are single-cycle pulses. They also assume that no write arrives during reset, and that the PLL strobe is already valid whenever the PLL source is chosen, since lock is not modelled. The stimulus holds both strobes high on every cycle, so the source periods are exactly two cycles and one cycle. It issues writes only after reset has been released, and always as one-cycle strobes with a settle gap before any rate is measured.

// File: rtl/clkgear_pkg.sv
// Shared widths, control word field positions and the settings record.
// Assumes the gear field is at most a few bits wide (ratio up to 2^(2^GEAR_W-1)).
package clkgear_pkg;
    localparam int GEAR_W = 2;
    localparam int MUL_W  = 2;
    localparam int WORD_W = 7;
    localparam int F_SRC  = 0;
    localparam int F_GEAR = 1;
    localparam int F_DBL  = F_GEAR + GEAR_W;
    localparam int F_MUL  = F_DBL + 1;
    localparam int F_CLR  = F_MUL + MUL_W;
    localparam logic [MUL_W-1:0] MUL_TOP = '1;

    typedef struct packed {
        logic              src_pll;
        logic [GEAR_W-1:0] gear;
        logic              dbl;
        logic [MUL_W-1:0]  mul;
    } cfg_t;

    // Splits a control word into the settings record.
    function automatic cfg_t unpack_word(input logic [WORD_W-1:0] w);
        cfg_t c;
        c.src_pll = w[F_SRC];
        c.gear    = w[F_GEAR +: GEAR_W];
        c.dbl     = w[F_DBL];
        c.mul     = w[F_MUL +: MUL_W];
        return c;
    endfunction
endpackage

// File: rtl/clkgear_regs.sv
// Settings register with write legality checks and a sticky error flag.
// Assumes wr_en is a single-cycle strobe; the checks compare against the
// settings currently held, not the ones being written.
module clkgear_regs
    import clkgear_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output cfg_t              cfg,
    output logic              err
);
    cfg_t nxt;
    logic drop_dbl;
    logic mul_chg;
    logic inhibited;
    logic reject;

    // Decode the incoming word and classify it against the legality rules.
    always_comb begin
        nxt       = unpack_word(wr_data);
        drop_dbl  = cfg.src_pll && cfg.dbl && !nxt.dbl;
        mul_chg   = cfg.src_pll && (nxt.mul != cfg.mul);
        inhibited = nxt.src_pll && !nxt.dbl && (nxt.gear == '0) && (nxt.mul == MUL_TOP);
        reject    = drop_dbl || mul_chg || inhibited;
    end

    // Apply accepted writes; a rejected write only raises the error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
            err <= 1'b0;
        end else if (wr_en) begin
            if (reject) begin
                err <= 1'b1;
            end else begin
                cfg <= nxt;
                if (wr_data[F_CLR]) err <= 1'b0;
            end
        end
    end

    a_r5_mul_locked_on_pll: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.src_pll |=> $stable(cfg.mul));
    a_r4_dbl_kept_on_pll: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.src_pll && cfg.dbl) |=> cfg.dbl);
    a_r6_never_inhibited: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg.src_pll && !cfg.dbl && (cfg.gear == '0) && (cfg.mul == MUL_TOP)));
    a_r7_reject_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reject) |=> (err && $stable(cfg)));
endmodule

// File: rtl/clkgear_srcsel.sv
// Builds the halved-oscillator strobe and selects the active source strobe.
// Assumes osc_tick and pll_tick are single-cycle strobes on clk.
module clkgear_srcsel (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_tick,
    input  logic pll_tick,
    input  logic use_pll,
    output logic src_tick
);
    logic half_ph;
    logic div2_tick;

    // Toggle on each oscillator strobe so every second one passes.
    always_ff @(posedge clk) begin
        if (!rst_n)        half_ph <= 1'b0;
        else if (osc_tick) half_ph <= ~half_ph;
    end

    // Gate the oscillator strobe and pick the source.
    always_comb begin
        div2_tick = osc_tick && half_ph;
        src_tick  = use_pll ? pll_tick : div2_tick;
    end

    a_r2_div2_needs_osc: assert property (@(posedge clk) disable iff (!rst_n)
        (!use_pll && src_tick) |-> osc_tick);
endmodule

// File: rtl/clkgear_divider.sv
// Gear divider and doubler phase: turns source strobes into core and bus
// enables. New gear/doubler requests are loaded only at a period boundary.
// Assumes src_tick is a single-cycle strobe; outputs are registered.
module clkgear_divider
    import clkgear_pkg::*;
#(
    parameter int CNT_W = (1 << GEAR_W) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_tick,
    input  logic [GEAR_W-1:0] gear_req,
    input  logic              dbl_req,
    output logic [GEAR_W-1:0] act_gear,
    output logic              cpu_en,
    output logic              bus_en
);
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  last_cnt;
    logic [GEAR_W-1:0] eff_req;
    logic              act_dbl;
    logic              phase;

    // Terminal count of the active ratio and the forced-1/1 request.
    always_comb begin
        last_cnt = CNT_W'((32'd1 << act_gear) - 32'd1);
        eff_req  = dbl_req ? '0 : gear_req;
    end

    // Count source strobes, pulse at the terminal count, reload settings there.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            act_gear <= '0;
            act_dbl  <= 1'b0;
            phase    <= 1'b0;
            cpu_en   <= 1'b0;
            bus_en   <= 1'b0;
        end else begin
            cpu_en <= 1'b0;
            bus_en <= 1'b0;
            if (src_tick) begin
                if (cnt == last_cnt) begin
                    cnt      <= '0;
                    cpu_en   <= 1'b1;
                    bus_en   <= act_dbl ? phase : 1'b1;
                    phase    <= act_dbl ? ~phase : 1'b0;
                    act_gear <= eff_req;
                    act_dbl  <= dbl_req;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    a_r3_bus_inside_cpu: assert property (@(posedge clk) disable iff (!rst_n)
        bus_en |-> cpu_en);
    a_r3_gear_forced: assert property (@(posedge clk) disable iff (!rst_n)
        act_dbl |-> (act_gear == '0));
    a_r9_gear_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_gear) |-> cpu_en);
    a_r2_bus_follows_cpu: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_en && !act_dbl && !$stable(cpu_en)) |-> bus_en);
endmodule

// File: rtl/clkgear_ctrl.sv
// Top of the clock gear and doubler controller: settings register, source
// selection and gear divider. Assumes strobe inputs are synchronous to clk.
module clkgear_ctrl
    import clkgear_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_tick,
    input  logic              pll_tick,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic              cpu_en,
    output logic              bus_en,
    output logic              src_pll,
    output logic [GEAR_W-1:0] gear_sel,
    output logic              dbl_on,
    output logic [MUL_W-1:0]  pll_mul,
    output logic [GEAR_W-1:0] eff_gear,
    output logic              cfg_err
);
    cfg_t cfg;
    logic src_tick;

    clkgear_regs regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cfg     (cfg),
        .err     (cfg_err)
    );

    clkgear_srcsel srcsel_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .osc_tick (osc_tick),
        .pll_tick (pll_tick),
        .use_pll  (cfg.src_pll),
        .src_tick (src_tick)
    );

    clkgear_divider div_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_tick (src_tick),
        .gear_req (cfg.gear),
        .dbl_req  (cfg.dbl),
        .act_gear (eff_gear),
        .cpu_en   (cpu_en),
        .bus_en   (bus_en)
    );

    // Expose the stored settings.
    always_comb begin
        src_pll  = cfg.src_pll;
        gear_sel = cfg.gear;
        dbl_on   = cfg.dbl;
        pll_mul  = cfg.mul;
    end
endmodule

// File: tb/clkgear_ctrl_tb_top.sv
module clkgear_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_tick = 1'b1;
    logic       pll_tick = 1'b1;
    logic       wr_en = 1'b0;
    logic [6:0] wr_data = '0;
    logic       cpu_en, bus_en, src_pll, dbl_on, cfg_err;
    logic [1:0] gear_sel, pll_mul, eff_gear;

    int n_tests = 0;
    int n_fail  = 0;
    localparam int WIN = 128;

    typedef struct { string req; int cpu; int bus; } exp_t;
    exp_t sbq[$];

    always #10 clk = ~clk;

    clkgear_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .pll_tick(pll_tick),
        .wr_en(wr_en), .wr_data(wr_data), .cpu_en(cpu_en), .bus_en(bus_en),
        .src_pll(src_pll), .gear_sel(gear_sel), .dbl_on(dbl_on),
        .pll_mul(pll_mul), .eff_gear(eff_gear), .cfg_err(cfg_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Write one control word: source, gear, doubler, PLL code, error clear.
    task automatic wr(input bit s, input int g, input bit d, input int m, input bit c);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = {c, m[1:0], d, g[1:0], s};
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // Driver side of the scoreboard: push expected pulse counts for one window.
    task automatic expect_rate(input string req, input int c, input int b);
        repeat (40) @(negedge clk);
        sbq.push_back('{req, c, b});
        wait (sbq.size() == 0);
        @(negedge clk);
    endtask

    // Monitor: count enables over a window and compare with the queued item.
    initial begin
        int c;
        int b;
        exp_t e;
        forever begin
            @(negedge clk);
            if (sbq.size() > 0) begin
                c = 0;
                b = 0;
                for (int i = 0; i < WIN; i++) begin
                    if (cpu_en) c++;
                    if (bus_en) b++;
                    @(negedge clk);
                end
                e = sbq[0];
                chk({e.req, " cpu_en count"}, c, e.cpu);
                chk({e.req, " bus_en count"}, b, e.bus);
                void'(sbq.pop_front());
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int g;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 src", src_pll, 0);
        chk("R10 gear", gear_sel, 0);
        chk("R10 dbl", dbl_on, 0);
        chk("R10 mul", pll_mul, 0);
        chk("R10 err", cfg_err, 0);
        chk("R10 cpu_en", cpu_en, 0);
        // R2 halved oscillator, 1/1: period 2
        expect_rate("R2 div2 1/1", 64, 64);
        // R1 R2 gear 1/4 on halved oscillator: period 8
        wr(0, 2, 0, 0, 0);
        expect_rate("R2 div2 1/4", 16, 16);
        chk("R1 eff_gear", eff_gear, 2);
        wr(0, 3, 0, 0, 0);
        expect_rate("R2 div2 1/8", 8, 8);
        // R2 PLL source, code change legal from halved source
        wr(1, 1, 0, 1, 0);
        chk("R1 src_pll", src_pll, 1);
        chk("R1 pll_mul", pll_mul, 1);
        expect_rate("R2 pll 1/2", 64, 64);
        // R3 doubler on
        wr(1, 2, 1, 1, 0);
        expect_rate("R3 pll dbl", 128, 64);
        chk("R3 eff_gear", eff_gear, 0);
        chk("R3 gear field kept", gear_sel, 2);
        // R4 R7 doubler off on PLL rejected
        wr(1, 3, 0, 1, 0);
        chk("R4 err", cfg_err, 1);
        chk("R7 dbl kept", dbl_on, 1);
        chk("R7 gear kept", gear_sel, 2);
        expect_rate("R7 rate kept", 128, 64);
        // R8 clear by accepted write
        wr(1, 2, 1, 1, 1);
        chk("R8 cleared", cfg_err, 0);
        // R5 code change on PLL rejected
        wr(1, 2, 1, 2, 0);
        chk("R5 err", cfg_err, 1);
        chk("R5 mul kept", pll_mul, 1);
        // R8 rejected write with clear bit keeps flag
        wr(1, 2, 1, 3, 1);
        chk("R8 kept on reject", cfg_err, 1);
        wr(1, 2, 1, 1, 1);
        chk("R8 cleared again", cfg_err, 0);
        // R3 doubler on halved oscillator
        wr(0, 2, 1, 1, 0);
        chk("R3 accepted", cfg_err, 0);
        expect_rate("R3 div2 dbl", 64, 32);
        wr(0, 2, 0, 3, 0);
        chk("R4 off on div2 ok", cfg_err, 0);
        chk("R5 mul on div2 ok", pll_mul, 3);
        expect_rate("R2 div2 1/4 again", 16, 16);
        // R6 inhibited combination
        wr(1, 0, 0, 3, 0);
        chk("R6 err", cfg_err, 1);
        chk("R6 src kept", src_pll, 0);
        wr(1, 1, 0, 3, 1);
        chk("R6 neighbour ok", cfg_err, 0);
        chk("R6 src now pll", src_pll, 1);
        expect_rate("R6 pll 1/2", 64, 64);
        // R9 gear change waits for the boundary
        wr(0, 3, 0, 3, 0);
        expect_rate("R9 setup 1/8", 8, 8);
        @(negedge clk);
        while (!cpu_en) @(negedge clk);
        wr_en   = 1'b1;
        wr_data = {1'b0, 2'd3, 1'b0, 2'd0, 1'b0};
        g = 0;
        do begin
            @(negedge clk);
            wr_en = 1'b0;
            g++;
        end while (!cpu_en);
        chk("R9 old period completes", g, 16);
        g = 0;
        do begin
            @(negedge clk);
            g++;
        end while (!cpu_en);
        chk("R9 new period", g, 2);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule